// File: doc/BRIEF.md
# Pixel Depth Expansion and Range Clamp

This stage sits at the output end of a display pipe that carries 12 bits per colour channel. Content that was produced at 8 or 10 bits arrives MSB-aligned on the 12-bit bus. When expansion is enabled, the missing low bits are filled by replicating the channel's top bits, so black stays at zero and full scale stays at full scale. After expansion, each channel can be limited to the legal video window for a chosen depth. The low ends of those windows are the 8-, 10- and 12-bit codes 16, 64 and 256, and the high ends are 235, 940 and 3760. Each bound is widened to 12 bits by the same replication, so a limited-range signal that was expanded from its own depth passes through unchanged.

Two small codes control the stage. The expansion mode selects the source depth: 0 for 10-bit and 1 for 8-bit. The clamp format selects the window: 1 for 8-bit, 2 for 10-bit and 3 for 12-bit. Format 0 means full range, and format 7 is reserved for bounds that are programmed elsewhere. Neither of these two clamps anything here. All three channels are handled identically and independently. The result appears one clock after a valid input, and the output holds its value while no valid pixel arrives.

Top module: `pix_expand_clamp`

## Requirements
- R1: While rst_ni is low, vld_o is 0 and pix_o is all zeros.
- R2: vld_o is equal to vld_i from the previous clock edge, so the latency is exactly one cycle.
- R3: With exp_en_i=0 and clamp_en_i=0, each output channel equals its input channel.
- R4: With exp_en_i=1 and exp_mode_i=0 (10-bit source), a channel v becomes {v[11:2], v[11:10]}.
- R5: With exp_en_i=1 and exp_mode_i=1 (8-bit source), a channel v becomes {v[11:4], v[11:8]}.
- R6: With clamp_en_i=1 and clamp_fmt_i=1, each channel is limited to the range 257 to 3774.
- R7: With clamp_en_i=1 and clamp_fmt_i=2, each channel is limited to the range 256 to 3763.
- R8: With clamp_en_i=1 and clamp_fmt_i=3, each channel is limited to the range 256 to 3760.
- R9: clamp_en_i=0, or a clamp_fmt_i value of 0 or 4 to 7, leaves the data unclamped.
- R10: Expansion is applied before the clamp comparison.
- R11: A cycle with vld_i=0 leaves pix_o unchanged.
- R12: Channel k occupies pix_i[12k+11:12k] and pix_o[12k+11:12k], and is processed with no dependence on the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Input pixel valid |
| pix_i | input | 36 | Three 12-bit channels; channel k is at bits [12k+11:12k] |
| exp_en_i | input | 1 | Enables depth expansion |
| exp_mode_i | input | 1 | Source depth: 0 for 10-bit, 1 for 8-bit |
| clamp_en_i | input | 1 | Enables the range clamp |
| clamp_fmt_i | input | 3 | Clamp window: 1 for 8-bit, 2 for 10-bit, 3 for 12-bit; other values do not clamp |
| vld_o | output | 1 | Output pixel valid |
| pix_o | output | 36 | Processed channels, in the same layout as pix_i |

## Verification
The hardest case to reach is one where the order of expansion and clamping changes the result. This only happens for input codes that sit just below a bound, where the replicated low bits carry the value across that bound. The sweep covers every combination of the control codes. It mixes a strided sweep of input values with codes placed directly on and beside each widened bound. A directed pixel (code 255, 8-bit mode, 12-bit clamp) separates expand-then-clamp from clamp-then-expand.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam logic [2:0] CLF_FULL = 3'd0;
  localparam logic [2:0] CLF_D8   = 3'd1;
  localparam logic [2:0] CLF_D10  = 3'd2;
  localparam logic [2:0] CLF_D12  = 3'd3;

  // widen a d-bit code to w bits by replicating its top bits (needs 2d >= w)
  function automatic int unsigned widen(int unsigned val, int d, int w);
    return (val << (w - d)) | (val >> (2 * d - w));
  endfunction

  // limited-range codes scaled from their 8-bit definition to depth d
  function automatic int unsigned lim_lo(int d, int w);
    return widen(32'd16 << (d - 8), d, w);
  endfunction

  function automatic int unsigned lim_hi(int d, int w);
    return widen(32'd235 << (d - 8), d, w);
  endfunction
endpackage

// File: rtl/pxc_expand.sv
module pxc_expand #(
  parameter int W    = 12,
  parameter int SH_A = 2,   // mode 0: W-2 bit source
  parameter int SH_B = 4    // mode 1: W-4 bit source
) (
  input  logic         en_i,
  input  logic         mode_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  logic [W-1:0] fill_a, fill_b;

  assign fill_a = {d_i[W-1:SH_A], d_i[W-1 -: SH_A]};
  assign fill_b = {d_i[W-1:SH_B], d_i[W-1 -: SH_B]};

  always_comb begin
    if (!en_i)       d_o = d_i;
    else if (mode_i) d_o = fill_b;
    else             d_o = fill_a;
  end
endmodule

// File: rtl/pxc_clamp.sv
module pxc_clamp #(
  parameter int           W   = 12,
  parameter logic [W-1:0] LO1 = '0,
  parameter logic [W-1:0] HI1 = '1,
  parameter logic [W-1:0] LO2 = '0,
  parameter logic [W-1:0] HI2 = '1,
  parameter logic [W-1:0] LO3 = '0,
  parameter logic [W-1:0] HI3 = '1
) (
  input  logic         en_i,
  input  logic [2:0]   fmt_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  import pxc_pkg::*;

  logic         act;
  logic [W-1:0] lo, hi;

  always_comb begin
    act = en_i;
    lo  = '0;
    hi  = '1;
    case (fmt_i)
      CLF_D8:  begin lo = LO1; hi = HI1; end
      CLF_D10: begin lo = LO2; hi = HI2; end
      CLF_D12: begin lo = LO3; hi = HI3; end
      default: act = 1'b0;   // full range, programmable, unlisted
    endcase
  end

  always_comb begin
    if (act && d_i < lo)      d_o = lo;
    else if (act && d_i > hi) d_o = hi;
    else                      d_o = d_i;
  end
endmodule

// File: rtl/pix_expand_clamp.sv
module pix_expand_clamp #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [NCH*W-1:0] pix_i,
  input  logic             exp_en_i,
  input  logic             exp_mode_i,
  input  logic             clamp_en_i,
  input  logic [2:0]       clamp_fmt_i,
  output logic             vld_o,
  output logic [NCH*W-1:0] pix_o
);
  import pxc_pkg::*;

  localparam int D1 = W - 4;
  localparam int D2 = W - 2;
  localparam int D3 = W;
  localparam logic [W-1:0] LO1 = W'(lim_lo(D1, W));
  localparam logic [W-1:0] HI1 = W'(lim_hi(D1, W));
  localparam logic [W-1:0] LO2 = W'(lim_lo(D2, W));
  localparam logic [W-1:0] HI2 = W'(lim_hi(D2, W));
  localparam logic [W-1:0] LO3 = W'(lim_lo(D3, W));
  localparam logic [W-1:0] HI3 = W'(lim_hi(D3, W));

  logic [NCH*W-1:0] nxt;

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [W-1:0] ex;

    pxc_expand #(.W(W), .SH_A(W - D2), .SH_B(W - D1)) u_exp (
      .en_i  (exp_en_i),
      .mode_i(exp_mode_i),
      .d_i   (pix_i[k*W +: W]),
      .d_o   (ex)
    );

    pxc_clamp #(.W(W), .LO1(LO1), .HI1(HI1), .LO2(LO2), .HI2(HI2),
                .LO3(LO3), .HI3(HI3)) u_clp (
      .en_i (clamp_en_i),
      .fmt_i(clamp_fmt_i),
      .d_i  (ex),
      .d_o  (nxt[k*W +: W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      pix_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) pix_o <= nxt;
    end
  end
endmodule

// File: rtl/pxc_chk.sv
module pxc_chk #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vld_i,
  input logic [NCH*W-1:0] pix_i,
  input logic             exp_en_i,
  input logic             exp_mode_i,
  input logic             clamp_en_i,
  input logic [2:0]       clamp_fmt_i,
  input logic             vld_o,
  input logic [NCH*W-1:0] pix_o
);
  import pxc_pkg::*;

  localparam logic [W-1:0] LO1 = W'(lim_lo(W - 4, W));
  localparam logic [W-1:0] HI1 = W'(lim_hi(W - 4, W));
  localparam logic [W-1:0] LO3 = W'(lim_lo(W, W));
  localparam logic [W-1:0] HI3 = W'(lim_hi(W, W));

  always_comb begin
    if (!rst_ni) a_r1_reset_idle: assert (vld_o == 1'b0 && pix_o == '0);
  end

  a_r2_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> vld_o);
  a_r2_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> !vld_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(pix_o));
  a_r3_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !exp_en_i && !clamp_en_i) |=> pix_o == $past(pix_i));

  for (genvar k = 0; k < NCH; k++) begin : g_rng
    a_r6_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && clamp_en_i && clamp_fmt_i == CLF_D8) |=>
        (pix_o[k*W +: W] >= LO1 && pix_o[k*W +: W] <= HI1));
    a_r8_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (vld_i && clamp_en_i && clamp_fmt_i == CLF_D12) |=>
        (pix_o[k*W +: W] >= LO3 && pix_o[k*W +: W] <= HI3));
  end
endmodule

bind pix_expand_clamp pxc_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vld_i      (vld_i),
  .pix_i      (pix_i),
  .exp_en_i   (exp_en_i),
  .exp_mode_i (exp_mode_i),
  .clamp_en_i (clamp_en_i),
  .clamp_fmt_i(clamp_fmt_i),
  .vld_o      (vld_o),
  .pix_o      (pix_o)
);

// File: tb/sim_pix_expand_clamp.sv
module sim_pix_expand_clamp;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        vld_i = 1'b0;
  logic [35:0] pix_i = '0;
  logic        exp_en_i = 1'b0;
  logic        exp_mode_i = 1'b0;
  logic        clamp_en_i = 1'b0;
  logic [2:0]  clamp_fmt_i = 3'd0;
  logic        vld_o;
  logic [35:0] pix_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk_i = ~clk_i;

  pix_expand_clamp u0 (.*);

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int model(int v, bit en, bit m, bit cen, int f);
    int x = v;
    int lo = 0;
    int hi = 4095;
    if (en) x = m ? ((v & 4080) | (v >> 8)) : ((v & 4092) | (v >> 10));
    if (cen) begin
      case (f)
        1: begin lo = 16 * 16 + 1; hi = 235 * 16 + 14; end
        2: begin lo = 64 * 4;      hi = 940 * 4 + 3;   end
        3: begin lo = 256;         hi = 3760;          end
        default: ;
      endcase
    end
    if (x < lo) x = lo;
    if (x > hi) x = hi;
    return x;
  endfunction

  function automatic string tag_of(bit en, bit m, bit cen, int f);
    if (cen && f == 1) return "R6";
    if (cen && f == 2) return "R7";
    if (cen && f == 3) return "R8";
    if (cen)           return "R9";
    if (en)            return m ? "R5" : "R4";
    return "R3";
  endfunction

  task automatic xfer(int a, int b, int c, bit en, bit m, bit cen, int f, string tg);
    @(negedge clk_i);
    vld_i = 1'b1;
    pix_i = {12'(c), 12'(b), 12'(a)};
    exp_en_i = en; exp_mode_i = m; clamp_en_i = cen; clamp_fmt_i = 3'(f);
    @(negedge clk_i);
    vld_i = 1'b0;
    check("R2", int'(vld_o), 1);
    check(tg, int'(pix_o[11:0]),  model(a, en, m, cen, f));
    check(tg, int'(pix_o[23:12]), model(b, en, m, cen, f));
    check(tg, int'(pix_o[35:24]), model(c, en, m, cen, f));
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int edges[9] = '{0, 255, 256, 257, 3760, 3763, 3774, 3775, 4095};
    logic [35:0] held;
    #23;
    check("R1", int'(vld_o), 0);
    check("R1", int'(pix_o[35:0] != 0), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int cfg = 0; cfg < 64; cfg++) begin
      bit en  = cfg[5];
      bit m   = cfg[4];
      bit cen = cfg[3];
      int f   = cfg & 7;
      string tg = tag_of(en, m, cen, f);
      for (int v = 0; v < 4096; v += 37)
        xfer(v, 4095 - v, (v * 7) & 4095, en, m, cen, f, tg);
      foreach (edges[i])
        xfer(edges[i], edges[(i + 3) % 9], edges[(i + 6) % 9], en, m, cen, f, tg);
    end

    // R10: 255 in 8-bit mode expands to 240, then clamps to 256 (257 if reversed)
    xfer(255, 255, 255, 1'b1, 1'b1, 1'b1, 3, "R10");
    check("R10", int'(pix_o[11:0]), 256);

    // R12: only channel 1 is out of window, neighbours untouched
    xfer(1000, 10, 2000, 1'b0, 1'b0, 1'b1, 3, "R12");
    check("R12", int'(pix_o[11:0]), 1000);
    check("R12", int'(pix_o[23:12]), 256);
    check("R12", int'(pix_o[35:24]), 2000);

    // R11: invalid cycles with new data leave the output frozen
    held = pix_o;
    @(negedge clk_i);
    vld_i = 1'b0;
    pix_i = 36'hABC_123_FFF;
    exp_en_i = 1'b0; clamp_en_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R11", int'(pix_o == held), 1);
    check("R2", int'(vld_o), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule